// File: doc/BRIEF.md
# Bus Window Decoder with Boot Overlay

This block sits between a 24-bit, byte-addressed, big-endian processor bus and the targets behind it. Each cycle in which a request is presented, it classifies the access by address, size and direction. It then produces one registered response: a one-hot select for RAM, boot ROM or one of ten peripheral windows, the local offset inside the chosen target, byte-lane enables, and an error flag for any access that has no legal home. The memories, the peripherals and the processor are outside the block.

A small state machine handles start-up. It has two states.

- `OVL_ACTIVE` is entered at reset. In this state only the two reset-vector long reads, at addresses 0 and 4, are legal, and both are steered to the start of ROM. Any other access is flagged as an error.
- `OVL_DONE` is normal decoding. The one transition, OVL_ACTIVE to OVL_DONE, fires when the vector read at address 4 is accepted. Nothing leads back except reset.

A configurable window, whose bounds are written through a small configuration port, lets ROM-resident code keep its zero-initialised data in RAM.

Top module: `memmap_router`

## Requirements
- R1: The response is registered. `rsp_valid` is high exactly in the cycle after `req_valid` was sampled high. While `rsp_valid` is low, every select, `rsp_offset`, `rsp_lanes` and `rsp_error` are zero.
- R2: A valid response without error has exactly one select high, out of `rsp_ram_sel`, `rsp_rom_sel` and the bits of `rsp_periph_sel`. An error response has no select high, and zero offset and lanes.
- R3: After reset the block is in OVL_ACTIVE.
  - A long read at address 0 selects ROM with offset 0 and stays in OVL_ACTIVE.
  - A long read at address 4 selects ROM with offset 4 and moves to OVL_DONE.
  - OVL_DONE is left only by reset, so after it the same addresses decode as ordinary RAM.
- R4: In OVL_ACTIVE, every other access raises the error flag and leaves the state unchanged. This includes writes and reads of other sizes or addresses.
- R5: Reads inside ROM (0x100000 up to, but excluding, 0x110000) select ROM with offset addr - 0x100000. A write there selects no ROM and raises an error, unless the access falls inside the RAM-steered window of R9.
- R6: The peripheral windows are tried in index order, and the first hit wins. Bit i of `rsp_periph_sel` is window i.
  - Window 0 covers 0x180000 up to 0x200000.
  - Window 1 covers 0x200000 up to 0x280000.
  - Window 2+k, for k = 0..7, starts at 0x3A0001 + k*0x4000 and spans 0x4000 bytes.
  - Every upper bound is exclusive.
- R7: The peripheral offset is addr - base for a window with an even base, and (addr - base) >> 1 for a window with an odd base.
- R8: A region is chosen only if the whole access fits: addr + bytes - 1 must lie below the region's exclusive end. An access that straddles a boundary matches nothing on that side.
- R9: The RAM-steered window runs from a start bound (written with `cfg_sel`=0) up to an exclusive end bound (written with `cfg_sel`=1).
  - Both bounds reset to 0, which gives an empty window.
  - Reads and writes that fit inside the window select RAM with offset equal to the address.
  - A ROM read takes priority over the window.
  - A bound written at a clock edge applies to requests sampled at later edges, not to the request sampled at the same edge.
- R10: An access that fits below 0x010000 and hits no other region selects RAM with offset equal to the address. Any other unmatched access raises an error.
- R11: Lane enables describe a right-aligned big-endian value, where bit 3 is data bits 31:24 and bit 0 is bits 7:0. A byte access gives 0001, a word gives 0011 (the lower address on bits 15:8), and a long gives 1111.
- R12: `req_size` encodes the access size: 0 is byte, 1 is word, 2 is long, and 3 is illegal and always raises an error. A word or long access at an odd address raises an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 24 | Byte address of the access |
| req_size | input | 2 | 0 byte, 1 word, 2 long, 3 illegal |
| req_write | input | 1 | 1 for write, 0 for read |
| cfg_we | input | 1 | Write a RAM-steered window bound |
| cfg_sel | input | 1 | 0 start bound, 1 exclusive end bound |
| cfg_data | input | 24 | Bound value |
| rsp_valid | output | 1 | Registered response present |
| rsp_ram_sel | output | 1 | RAM selected |
| rsp_rom_sel | output | 1 | Boot ROM selected |
| rsp_periph_sel | output | 10 | One-hot peripheral window select |
| rsp_offset | output | 24 | Offset inside the selected target |
| rsp_lanes | output | 4 | Active byte lanes |
| rsp_error | output | 1 | Unmapped or illegal access |

## Verification
Two functions can fall in the same cycle: a bound update of the RAM-steered window, and a request that the new bound would decide.

The bench provokes this by writing the window's end bound in the very cycle it presents a long read at the window start. The response is judged against the old, empty window, which means an error. The bench then repeats the read one cycle later, when it must select RAM.

A second overlap is a ROM read inside a window that has been moved over ROM. That read must still go to ROM, while a write at the same address goes to RAM.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    typedef enum logic {
        OVL_ACTIVE = 1'b0,
        OVL_DONE   = 1'b1
    } boot_state_e;

    typedef enum logic [1:0] {
        RT_ERROR  = 2'd0,
        RT_RAM    = 2'd1,
        RT_ROM    = 2'd2,
        RT_PERIPH = 2'd3
    } route_e;

    function automatic logic [2:0] size_to_bytes(input logic [1:0] sz);
        logic [2:0] n;
        unique case (sz)
            SZ_BYTE: n = 3'd1;
            SZ_WORD: n = 3'd2;
            SZ_LONG: n = 3'd4;
            default: n = 3'd0;
        endcase
        return n;
    endfunction

    function automatic logic [3:0] size_to_lanes(input logic [1:0] sz);
        logic [3:0] l;
        unique case (sz)
            SZ_BYTE: l = 4'b0001;
            SZ_WORD: l = 4'b0011;
            SZ_LONG: l = 4'b1111;
            default: l = 4'b0000;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/memmap_boot_fsm.sv
module memmap_boot_fsm
    import memmap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic acc_fire,
    input  logic acc_is_last_vec,
    output logic overlay_on
);

    boot_state_e state_q;
    boot_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OVL_ACTIVE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OVL_ACTIVE: if (acc_fire && acc_is_last_vec) state_d = OVL_DONE;
            OVL_DONE:   state_d = OVL_DONE;
        endcase
    end

    always_comb begin
        overlay_on = (state_q == OVL_ACTIVE);
    end

endmodule

// File: rtl/memmap_bss_cfg.sv
module memmap_bss_cfg #(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_data,
    output logic [ADDR_W-1:0] lo_q,
    output logic [ADDR_W-1:0] hi_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (cfg_we) begin
            if (cfg_sel) begin
                hi_q <= cfg_data;
            end else begin
                lo_q <= cfg_data;
            end
        end
    end

endmodule

// File: rtl/memmap_periph_match.sv
module memmap_periph_match #(
    parameter int                ADDR_W      = 24,
    parameter logic [ADDR_W-1:0] WIDE0_BASE  = 24'h180000,
    parameter logic [ADDR_W-1:0] WIDE0_SPAN  = 24'h080000,
    parameter logic [ADDR_W-1:0] WIDE1_BASE  = 24'h200000,
    parameter logic [ADDR_W-1:0] WIDE1_SPAN  = 24'h080000,
    parameter int                N_NARROW    = 8,
    parameter logic [ADDR_W-1:0] NARROW_BASE = 24'h3A0001,
    parameter logic [ADDR_W-1:0] NARROW_SPAN = 24'h004000,
    localparam int               N_WIN       = 2 + N_NARROW
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W:0]   acc_end,
    output logic [N_WIN-1:0]  sel,
    output logic [ADDR_W-1:0] offset
);

    localparam int AW1 = ADDR_W + 1;

    logic [N_WIN-1:0]  raw_hit;
    logic [ADDR_W-1:0] win_off [N_WIN];

    for (genvar gi = 0; gi < N_WIN; gi++) begin : g_win
        localparam logic [ADDR_W:0] BASE =
            (gi == 0) ? {1'b0, WIDE0_BASE} :
            (gi == 1) ? {1'b0, WIDE1_BASE} :
            {1'b0, NARROW_BASE} + AW1'(gi - 2) * {1'b0, NARROW_SPAN};
        localparam logic [ADDR_W:0] SPAN =
            (gi == 0) ? {1'b0, WIDE0_SPAN} :
            (gi == 1) ? {1'b0, WIDE1_SPAN} :
            {1'b0, NARROW_SPAN};
        localparam logic [ADDR_W:0] LIMIT = BASE + SPAN;
        localparam bit ODD_BASE = BASE[0];

        logic [ADDR_W:0] rel;
        assign rel         = {1'b0, addr} - BASE;
        assign raw_hit[gi] = ({1'b0, addr} >= BASE) && (acc_end <= LIMIT);
        assign win_off[gi] = ODD_BASE ? rel[ADDR_W:1] : rel[ADDR_W-1:0];
    end

    // lowest index wins: scan from the top so the last assignment is the winner
    always_comb begin
        sel    = '0;
        offset = '0;
        for (int i = N_WIN - 1; i >= 0; i--) begin
            if (raw_hit[i]) begin
                sel    = '0;
                sel[i] = 1'b1;
                offset = win_off[i];
            end
        end
    end

endmodule

// File: rtl/memmap_router.sv
module memmap_router
    import memmap_pkg::*;
#(
    parameter int                ADDR_W      = 24,
    parameter logic [ADDR_W-1:0] ROM_BASE    = 24'h100000,
    parameter logic [ADDR_W-1:0] ROM_SPAN    = 24'h010000,
    parameter logic [ADDR_W-1:0] LOW_RAM_TOP = 24'h010000,
    parameter logic [ADDR_W-1:0] WIDE0_BASE  = 24'h180000,
    parameter logic [ADDR_W-1:0] WIDE0_SPAN  = 24'h080000,
    parameter logic [ADDR_W-1:0] WIDE1_BASE  = 24'h200000,
    parameter logic [ADDR_W-1:0] WIDE1_SPAN  = 24'h080000,
    parameter int                N_NARROW    = 8,
    parameter logic [ADDR_W-1:0] NARROW_BASE = 24'h3A0001,
    parameter logic [ADDR_W-1:0] NARROW_SPAN = 24'h004000,
    localparam int               N_WIN       = 2 + N_NARROW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_data,
    output logic              rsp_valid,
    output logic              rsp_ram_sel,
    output logic              rsp_rom_sel,
    output logic [N_WIN-1:0]  rsp_periph_sel,
    output logic [ADDR_W-1:0] rsp_offset,
    output logic [3:0]        rsp_lanes,
    output logic              rsp_error
);

    localparam int              AW1       = ADDR_W + 1;
    localparam logic [ADDR_W:0] ROM_LIMIT = {1'b0, ROM_BASE} + {1'b0, ROM_SPAN};

    logic              overlay_on;
    logic [ADDR_W-1:0] bss_lo;
    logic [ADDR_W-1:0] bss_hi;
    logic [N_WIN-1:0]  per_sel;
    logic [ADDR_W-1:0] per_off;

    logic [2:0]        nbytes;
    logic [ADDR_W:0]   acc_end;
    logic              size_bad;
    logic              misalign;
    logic              vec_read;
    logic              vec_sp;
    logic              vec_pc;
    logic              rom_hit;
    logic              bss_hit;
    logic              low_hit;
    route_e            route;
    logic [ADDR_W-1:0] off_d;
    logic              take;

    assign nbytes   = size_to_bytes(req_size);
    assign acc_end  = {1'b0, req_addr} + AW1'(nbytes);
    assign size_bad = (req_size == SZ_BAD);
    assign misalign = ((req_size == SZ_WORD) || (req_size == SZ_LONG)) && req_addr[0];
    assign vec_read = !req_write && (req_size == SZ_LONG);
    assign vec_sp   = vec_read && (req_addr == '0);
    assign vec_pc   = vec_read && (req_addr == ADDR_W'(4));
    assign rom_hit  = ({1'b0, req_addr} >= {1'b0, ROM_BASE}) && (acc_end <= ROM_LIMIT);
    assign bss_hit  = ({1'b0, req_addr} >= {1'b0, bss_lo}) && (acc_end <= {1'b0, bss_hi});
    assign low_hit  = (acc_end <= {1'b0, LOW_RAM_TOP});

    memmap_boot_fsm u_boot (
        .clk             (clk),
        .rst_n           (rst_n),
        .acc_fire        (req_valid),
        .acc_is_last_vec (vec_pc),
        .overlay_on      (overlay_on)
    );

    memmap_bss_cfg #(.ADDR_W(ADDR_W)) u_bss (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_data (cfg_data),
        .lo_q     (bss_lo),
        .hi_q     (bss_hi)
    );

    memmap_periph_match #(
        .ADDR_W      (ADDR_W),
        .WIDE0_BASE  (WIDE0_BASE),
        .WIDE0_SPAN  (WIDE0_SPAN),
        .WIDE1_BASE  (WIDE1_BASE),
        .WIDE1_SPAN  (WIDE1_SPAN),
        .N_NARROW    (N_NARROW),
        .NARROW_BASE (NARROW_BASE),
        .NARROW_SPAN (NARROW_SPAN)
    ) u_per (
        .addr    (req_addr),
        .acc_end (acc_end),
        .sel     (per_sel),
        .offset  (per_off)
    );

    // routing priority: ROM read, steered window, peripherals, low RAM
    always_comb begin
        route = RT_ERROR;
        off_d = '0;
        if (overlay_on) begin
            if (vec_sp || vec_pc) begin
                route = RT_ROM;
                off_d = req_addr;
            end
        end else if (!size_bad && !misalign) begin
            if (rom_hit && !req_write) begin
                route = RT_ROM;
                off_d = req_addr - ROM_BASE;
            end else if (bss_hit) begin
                route = RT_RAM;
                off_d = req_addr;
            end else if (|per_sel) begin
                route = RT_PERIPH;
                off_d = per_off;
            end else if (low_hit) begin
                route = RT_RAM;
                off_d = req_addr;
            end
        end
    end

    assign take = req_valid && (route != RT_ERROR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid      <= 1'b0;
            rsp_ram_sel    <= 1'b0;
            rsp_rom_sel    <= 1'b0;
            rsp_periph_sel <= '0;
            rsp_offset     <= '0;
            rsp_lanes      <= '0;
            rsp_error      <= 1'b0;
        end else begin
            rsp_valid      <= req_valid;
            rsp_ram_sel    <= take && (route == RT_RAM);
            rsp_rom_sel    <= take && (route == RT_ROM);
            rsp_periph_sel <= (take && (route == RT_PERIPH)) ? per_sel : '0;
            rsp_offset     <= take ? off_d : '0;
            rsp_lanes      <= take ? size_to_lanes(req_size) : '0;
            rsp_error      <= req_valid && (route == RT_ERROR);
        end
    end

endmodule

// File: rtl/memmap_router_chk.sv
module memmap_router_chk #(
    parameter int ADDR_W = 24,
    parameter int N_WIN  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic              req_write,
    input logic              rsp_valid,
    input logic              rsp_ram_sel,
    input logic              rsp_rom_sel,
    input logic [N_WIN-1:0]  rsp_periph_sel,
    input logic [ADDR_W-1:0] rsp_offset,
    input logic [3:0]        rsp_lanes,
    input logic              rsp_error,
    input logic              overlay_on
);

    logic is_vector;
    assign is_vector = !req_write && (req_size == 2'd2) &&
                       ((req_addr == '0) || (req_addr == ADDR_W'(4)));

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_error && !rsp_ram_sel && !rsp_rom_sel &&
                        rsp_periph_sel == '0 && rsp_offset == '0 && rsp_lanes == '0)); // R1

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_error) |-> ($countones({rsp_ram_sel, rsp_rom_sel, rsp_periph_sel}) == 1)); // R2

    AST_ERR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_error |-> ({rsp_ram_sel, rsp_rom_sel, rsp_periph_sel} == '0 &&
                       rsp_lanes == '0 && rsp_offset == '0)); // R2

    AST_OVL_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
        !overlay_on |=> !overlay_on); // R3

    AST_OVL_STRAY: assert property (@(posedge clk) disable iff (!rst_n)
        (overlay_on && req_valid && !is_vector) |=> (rsp_error && overlay_on)); // R4

    AST_NO_ROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> !rsp_rom_sel); // R5

    AST_LANE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_error) |-> (rsp_lanes == 4'b0001 || rsp_lanes == 4'b0011 ||
                                       rsp_lanes == 4'b1111)); // R11

    AST_BAD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'd3) |=> rsp_error); // R12

    AST_ODD_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size != 2'd0 && req_addr[0]) |=> rsp_error); // R12

endmodule

bind memmap_router memmap_router_chk #(.ADDR_W(ADDR_W), .N_WIN(N_WIN)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_addr       (req_addr),
    .req_size       (req_size),
    .req_write      (req_write),
    .rsp_valid      (rsp_valid),
    .rsp_ram_sel    (rsp_ram_sel),
    .rsp_rom_sel    (rsp_rom_sel),
    .rsp_periph_sel (rsp_periph_sel),
    .rsp_offset     (rsp_offset),
    .rsp_lanes      (rsp_lanes),
    .rsp_error      (rsp_error),
    .overlay_on     (overlay_on)
);

// File: tb/memmap_router_test.sv
module memmap_router_test;

    localparam int CLK_PERIOD = 10;
    localparam int K_ERR = 0;
    localparam int K_RAM = 1;
    localparam int K_ROM = 2;
    localparam int K_PER = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [23:0] cfg_data = '0;
    logic        rsp_valid;
    logic        rsp_ram_sel;
    logic        rsp_rom_sel;
    logic [9:0]  rsp_periph_sel;
    logic [23:0] rsp_offset;
    logic [3:0]  rsp_lanes;
    logic        rsp_error;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    memmap_router uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_addr       (req_addr),
        .req_size       (req_size),
        .req_write      (req_write),
        .cfg_we         (cfg_we),
        .cfg_sel        (cfg_sel),
        .cfg_data       (cfg_data),
        .rsp_valid      (rsp_valid),
        .rsp_ram_sel    (rsp_ram_sel),
        .rsp_rom_sel    (rsp_rom_sel),
        .rsp_periph_sel (rsp_periph_sel),
        .rsp_offset     (rsp_offset),
        .rsp_lanes      (rsp_lanes),
        .rsp_error      (rsp_error)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // compare the whole response against an expectation built from kind, index and offset
    task automatic judge(input string tag, input logic [1:0] sz, input int kind,
                         input int idx, input logic [23:0] off);
        logic [40:0] got;
        logic [40:0] exp;
        logic [9:0]  eper;
        logic [3:0]  elanes;
        eper   = (kind == K_PER) ? (10'b1 << idx) : 10'b0;
        elanes = (kind == K_ERR) ? 4'b0000 :
                 (sz == 2'd0) ? 4'b0001 : (sz == 2'd1) ? 4'b0011 : 4'b1111;
        exp = {kind == K_RAM, kind == K_ROM, eper, (kind == K_ERR) ? 24'h0 : off,
               elanes, kind == K_ERR};
        got = {rsp_ram_sel, rsp_rom_sel, rsp_periph_sel, rsp_offset, rsp_lanes, rsp_error};
        checks++;
        if (!rsp_valid || got !== exp) begin
            errors++;
            $display("FAIL %s: valid=%0b ram=%0b rom=%0b per=%h off=%h lanes=%b err=%0b | expected valid=1 ram=%0b rom=%0b per=%h off=%h lanes=%b err=%0b",
                     tag, rsp_valid, got[40], got[39], got[38:29], got[28:5], got[4:1], got[0],
                     exp[40], exp[39], exp[38:29], exp[28:5], exp[4:1], exp[0]);
        end
    endtask

    task automatic acc(input string tag, input logic [23:0] a, input logic [1:0] sz,
                       input bit wr, input int kind, input int idx, input logic [23:0] off);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_size  = sz;
        req_write = wr;
        @(negedge clk);
        judge(tag, sz, kind, idx, off);
        req_valid = 1'b0;
    endtask

    task automatic set_bound(input bit hi, input logic [23:0] v);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_sel  = hi;
        cfg_data = v;
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    task automatic t_reset;
        checks++;
        if (rsp_valid || rsp_ram_sel || rsp_rom_sel || rsp_periph_sel != 0 ||
            rsp_offset != 0 || rsp_lanes != 0 || rsp_error) begin
            errors++;
            $display("FAIL R1 reset: valid=%0b err=%0b off=%h lanes=%b expected all zero",
                     rsp_valid, rsp_error, rsp_offset, rsp_lanes);
        end
    endtask

    task automatic t_boot;
        acc("R4 byte read in overlay", 24'h000100, 2'd0, 1'b0, K_ERR, 0, 0);
        acc("R4 long write to vector 0", 24'h000000, 2'd2, 1'b1, K_ERR, 0, 0);
        acc("R3 vector 0 to ROM", 24'h000000, 2'd2, 1'b0, K_ROM, 0, 24'h0);
        acc("R4 word read still overlay", 24'h000200, 2'd1, 1'b0, K_ERR, 0, 0);
        acc("R3 vector 4 to ROM", 24'h000004, 2'd2, 1'b0, K_ROM, 0, 24'h4);
        acc("R3 after exit addr 0 is RAM", 24'h000000, 2'd2, 1'b0, K_RAM, 0, 24'h0);
        acc("R3 after exit addr 4 is RAM", 24'h000004, 2'd2, 1'b0, K_RAM, 0, 24'h4);
    endtask

    task automatic t_idle;
        @(negedge clk);
        checks++;
        if (rsp_valid || rsp_error || rsp_ram_sel) begin
            errors++;
            $display("FAIL R1 idle cycle: valid=%0b err=%0b ram=%0b expected 0 0 0",
                     rsp_valid, rsp_error, rsp_ram_sel);
        end
    endtask

    task automatic t_rom;
        acc("R5 ROM long read", 24'h100010, 2'd2, 1'b0, K_ROM, 0, 24'h0010);
        acc("R5 ROM word write rejected", 24'h100020, 2'd1, 1'b1, K_ERR, 0, 0);
        acc("R5 ROM last long", 24'h10FFFC, 2'd2, 1'b0, K_ROM, 0, 24'hFFFC);
        acc("R8 ROM long straddles end", 24'h10FFFE, 2'd2, 1'b0, K_ERR, 0, 0);
        acc("R8 ROM last byte", 24'h10FFFF, 2'd0, 1'b0, K_ROM, 0, 24'hFFFF);
    endtask

    task automatic t_periph;
        acc("R6 window 0 base", 24'h180000, 2'd0, 1'b0, K_PER, 0, 24'h0);
        acc("R7 window 0 even offset", 24'h1FFFFE, 2'd1, 1'b0, K_PER, 0, 24'h07FFFE);
        acc("R8 long straddles windows 0 and 1", 24'h1FFFFE, 2'd2, 1'b0, K_ERR, 0, 0);
        acc("R6 window 1 long write", 24'h200004, 2'd2, 1'b1, K_PER, 1, 24'h4);
        acc("R6 window 2 base write", 24'h3A0001, 2'd0, 1'b1, K_PER, 2, 24'h0);
        acc("R7 window 2 odd base halves", 24'h3A0005, 2'd0, 1'b0, K_PER, 2, 24'h2);
        acc("R6 window 3 base", 24'h3A4001, 2'd0, 1'b0, K_PER, 3, 24'h0);
        acc("R7 window 9 top byte", 24'h3BFFFF, 2'd0, 1'b0, K_PER, 9, 24'h1FFF);
        acc("R6 below window 2", 24'h3A0000, 2'd0, 1'b0, K_ERR, 0, 0);
        acc("R6 window 9 end exclusive", 24'h3C0001, 2'd0, 1'b0, K_ERR, 0, 0);
    endtask

    task automatic t_align;
        acc("R12 word at odd peripheral addr", 24'h3A0001, 2'd1, 1'b0, K_ERR, 0, 0);
        acc("R12 size code 3", 24'h000010, 2'd3, 1'b0, K_ERR, 0, 0);
        acc("R12 long at odd addr", 24'h000101, 2'd2, 1'b0, K_ERR, 0, 0);
        acc("R12 long at addr 2 mod 4", 24'h000102, 2'd2, 1'b0, K_RAM, 0, 24'h000102);
    endtask

    task automatic t_low;
        acc("R11 word lanes low RAM", 24'h00FFFE, 2'd1, 1'b1, K_RAM, 0, 24'h00FFFE);
        acc("R10 long straddles low limit", 24'h00FFFE, 2'd2, 1'b0, K_ERR, 0, 0);
        acc("R11 byte lanes low RAM top", 24'h00FFFF, 2'd0, 1'b0, K_RAM, 0, 24'h00FFFF);
        acc("R10 unmapped mid RAM", 24'h050000, 2'd0, 1'b0, K_ERR, 0, 0);
        acc("R10 unmapped below ROM", 24'h0FFFFF, 2'd0, 1'b0, K_ERR, 0, 0);
    endtask

    task automatic t_bss;
        set_bound(1'b0, 24'h040000);
        // end bound written in the same cycle as the request: old empty window decides
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_sel   = 1'b1;
        cfg_data  = 24'h040100;
        req_valid = 1'b1;
        req_addr  = 24'h040000;
        req_size  = 2'd2;
        req_write = 1'b0;
        @(negedge clk);
        judge("R9 bound and request same cycle", 2'd2, K_ERR, 0, 0);
        cfg_we    = 1'b0;
        req_valid = 1'b0;
        acc("R9 window now open", 24'h040000, 2'd2, 1'b0, K_RAM, 0, 24'h040000);
        acc("R9 window last long write", 24'h0400FC, 2'd2, 1'b1, K_RAM, 0, 24'h0400FC);
        acc("R9 window long straddles end", 24'h0400FE, 2'd2, 1'b1, K_ERR, 0, 0);
        acc("R9 window top byte", 24'h0400FF, 2'd0, 1'b0, K_RAM, 0, 24'h0400FF);
        set_bound(1'b0, 24'h100000);
        set_bound(1'b1, 24'h100100);
        acc("R9 ROM read beats window", 24'h100000, 2'd2, 1'b0, K_ROM, 0, 24'h0);
        acc("R9 write over ROM goes to RAM", 24'h100000, 2'd2, 1'b1, K_RAM, 0, 24'h100000);
        acc("R5 write past window over ROM", 24'h100100, 2'd2, 1'b1, K_ERR, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_boot();
        t_idle();
        t_rom();
        t_periph();
        t_align();
        t_low();
        t_bss();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule